// File: doc/BRIEF.md
# Cascadable Event Down-Counter Bank

This block is a bank of 16-bit timer channels that count events instead of clock cycles. Each channel decrements once per qualified event. When it passes zero it reloads from its reload register and raises a one-cycle interrupt request, so a reload value n divides the event rate by n+1. An event is either a chosen edge of the channel's external input, or the underflow pulse of its cascade partner. The external input is re-timed through a two-flop synchroniser before its edges are detected.

Channels form groups of three, and two groups are instantiated by default. Inside a group, each channel's partner is the channel one index below it. The lowest channel of a group takes the highest channel of the same group as its partner. A register-style port writes a channel's count value and reads any channel's live count. The effect of a write depends on whether the channel has seen an event since it was last started. Before that first event, the write sets both the counter and the reload register. After it, the write sets only the reload register, and the new value first takes effect at the next reload.

Top module: `evt_timer_bank`

## Requirements
- R1: A channel with `run`=1 and `op_mode`=01 decrements its counter by one on each qualified event. An event at count 0 loads the reload value instead, so a reload value n gives one underflow every n+1 events.
- R2: With `src_casc`=0, `edge_mode` selects the edges of the synchronised input that count: 00 falling only, 01 rising only, 10 both. The value 11 counts no edge.
- R3: With `src_casc`=1, events come only from the partner's underflow and the input pin and `edge_mode` are ignored. The partner of channel i is i-1 within its group of three, and the first channel of a group uses the last channel of that group.
- R4: A write to a stopped channel, or to a running channel that has not yet seen an event since it was started, sets both the counter and the reload register to the written value.
- R5: A write to a running channel that has already seen an event changes only the reload register. The counter continues and picks up the new value at its next reload.
- R6: An underflow raises that channel's `irq` bit for exactly one cycle, in the same cycle that the reloaded count becomes visible on `rd_data`.
- R7: While `run`=0, or while `op_mode` is not 01, no event changes the counter.
- R8: `rd_data` shows the live counter of the channel selected by `rd_sel`. All counters are 0 after reset.
- R9: The first-event status of a channel clears while `run` is 0. After each restart, therefore, writes load both registers again until the next event.
- R10: When a write and a qualified event fall in the same cycle on a channel that has already seen an event, the event is applied to the counter and the written value goes to the reload register only.
- R11: A reload value of 0 gives an underflow on every event.
- R12: A pin edge changes the counter at the second rising clock edge after the first clock edge that samples the new pin level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_in | input | 6 | External event input per channel (asynchronous) |
| run | input | 6 | Per-channel start (1) / stop (0) |
| op_mode | input | 6x2 | Per-channel operating mode; 01 enables event counting |
| edge_mode | input | 6x2 | Per-channel edge selection for the pin source |
| src_casc | input | 6 | Per-channel source: 0 pin, 1 partner underflow |
| wr_en | input | 1 | Write strobe for the count value |
| wr_sel | input | 3 | Channel addressed by a write |
| wr_data | input | 16 | Written count value |
| rd_sel | input | 3 | Channel addressed by a read |
| rd_data | output | 16 | Live counter of the selected channel |
| irq | output | 6 | One-cycle underflow interrupt request per channel |

## Verification
A write and a qualified event can land on the same channel in the same cycle. Which of the two wins depends on whether the channel has already seen its first event. The bench provokes the collision by toggling a pin and asserting the write strobe two falling clock edges later, so that the write lines up with the cycle in which the synchronised edge is qualified. It then judges the result against a bench model that applies the event to the counter and the written value to the reload register, and it confirms that the next wrap reloads with the new value.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

    typedef enum logic [1:0] {
        EDGE_FALL = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_BOTH = 2'b10,
        EDGE_NONE = 2'b11
    } edge_mode_e;

    localparam logic [1:0] OPMODE_EVENT = 2'b01;

    // Cascade partner: one index below, wrapping inside the group.
    function automatic int casc_partner(input int idx, input int grp_sz);
        return ((idx % grp_sz) == 0) ? (idx + grp_sz - 1) : (idx - 1);
    endfunction

endpackage

// File: rtl/evt_pin_sync.sv
module evt_pin_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic pin_rise,
    output logic pin_fall
);

    typedef struct packed {
        logic meta;
        logic sync;
        logic prev;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = pin_async;
        st_d.sync = st_q.meta;
        st_d.prev = st_q.sync;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pin_rise = st_q.sync & ~st_q.prev;
    assign pin_fall = ~st_q.sync & st_q.prev;

    // R12
    edge_follows_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pin_rise |-> $past(st_q.meta));

endmodule

// File: rtl/evt_channel.sv
module evt_channel
    import evt_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [1:0]       op_mode,
    input  logic [1:0]       edge_mode,
    input  logic             src_casc,
    input  logic             pin_rise,
    input  logic             pin_fall,
    input  logic             casc_in,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] cnt_o,
    output logic             uf_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] reload;
        logic             seen;
        logic             uf;
    } chan_state_t;

    chan_state_t st_d, st_q;
    logic        edge_hit;
    logic        evt;
    logic        early;

    always_comb begin
        unique case (edge_mode_e'(edge_mode))
            EDGE_FALL: edge_hit = pin_fall;
            EDGE_RISE: edge_hit = pin_rise;
            EDGE_BOTH: edge_hit = pin_rise | pin_fall;
            default:   edge_hit = 1'b0;
        endcase
    end

    assign evt   = run && (op_mode == OPMODE_EVENT) && (src_casc ? casc_in : edge_hit);
    assign early = !(run && st_q.seen);

    always_comb begin
        st_d    = st_q;
        st_d.uf = 1'b0;
        if (evt) begin
            st_d.seen = 1'b1;
            if (st_q.cnt == '0) begin
                st_d.cnt = st_q.reload;
                st_d.uf  = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
        if (!run) begin
            st_d.seen = 1'b0;
        end
        if (wr_en) begin
            st_d.reload = wr_data;
            if (early) begin
                st_d.cnt = wr_data;
                st_d.uf  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;
    assign uf_o  = st_q.uf;

    // R1
    decrement_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && st_q.cnt != '0 && !wr_en) |=> (st_q.cnt == $past(st_q.cnt) - 1'b1));

    // R1
    reload_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && st_q.cnt == '0 && !wr_en) |=> (st_q.cnt == $past(st_q.reload) && uf_o));

    // R4
    early_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && early) |=> (st_q.cnt == $past(wr_data) && st_q.reload == $past(wr_data)));

    // R5
    late_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !early && !evt) |=> (st_q.cnt == $past(st_q.cnt) && st_q.reload == $past(wr_data)));

    // R7
    hold_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_en) |=> $stable(st_q.cnt));

    // R9
    seen_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !st_q.seen);

endmodule

// File: rtl/evt_timer_bank.sv
module evt_timer_bank
    import evt_timer_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int GROUPS   = 2,
    parameter int GROUP_SZ = 3,
    localparam int NCH     = GROUPS * GROUP_SZ,
    localparam int SEL_W   = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NCH-1:0]        ext_in,
    input  logic [NCH-1:0]        run,
    input  logic [NCH-1:0][1:0]   op_mode,
    input  logic [NCH-1:0][1:0]   edge_mode,
    input  logic [NCH-1:0]        src_casc,
    input  logic                  wr_en,
    input  logic [SEL_W-1:0]      wr_sel,
    input  logic [CNT_W-1:0]      wr_data,
    input  logic [SEL_W-1:0]      rd_sel,
    output logic [CNT_W-1:0]      rd_data,
    output logic [NCH-1:0]        irq
);

    logic [NCH-1:0]            rise;
    logic [NCH-1:0]            fall;
    logic [NCH-1:0]            uf;
    logic [NCH-1:0][CNT_W-1:0] cnt;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        localparam int PARTNER = casc_partner(g, GROUP_SZ);
        logic wr_hit;

        assign wr_hit = wr_en && (int'(wr_sel) == g);

        evt_pin_sync u_sync (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_async (ext_in[g]),
            .pin_rise  (rise[g]),
            .pin_fall  (fall[g])
        );

        evt_channel #(.CNT_W(CNT_W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .run       (run[g]),
            .op_mode   (op_mode[g]),
            .edge_mode (edge_mode[g]),
            .src_casc  (src_casc[g]),
            .pin_rise  (rise[g]),
            .pin_fall  (fall[g]),
            .casc_in   (uf[PARTNER]),
            .wr_en     (wr_hit),
            .wr_data   (wr_data),
            .cnt_o     (cnt[g]),
            .uf_o      (uf[g])
        );
    end

    always_comb begin
        rd_data = '0;
        if (int'(rd_sel) < NCH) begin
            rd_data = cnt[rd_sel];
        end
    end

    assign irq = uf;

    // R6
    irq_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq & ~$past(run)) == '0));

endmodule

// File: tb/evt_timer_bank_test.sv
module evt_timer_bank_test;

    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 6;
    localparam int CW         = 16;

    logic                clk = 1'b0;
    logic                rst_n;
    logic [NCH-1:0]      ext_in;
    logic [NCH-1:0]      run;
    logic [NCH-1:0][1:0] op_mode;
    logic [NCH-1:0][1:0] edge_mode;
    logic [NCH-1:0]      src_casc;
    logic                wr_en;
    logic [2:0]          wr_sel;
    logic [CW-1:0]       wr_data;
    logic [2:0]          rd_sel;
    logic [CW-1:0]       rd_data;
    logic [NCH-1:0]      irq;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    int m_cnt  [NCH];
    int m_rel  [NCH];
    bit m_seen [NCH];
    int m_irq  [NCH];
    int irq_seen [NCH];

    always #(CLK_PERIOD / 2) clk = ~clk;

    evt_timer_bank uut (
        .clk(clk), .rst_n(rst_n), .ext_in(ext_in), .run(run), .op_mode(op_mode),
        .edge_mode(edge_mode), .src_casc(src_casc), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            for (int c = 0; c < NCH; c++) if (irq[c]) irq_seen[c]++;
        end
    end

    function automatic int consumer_of(int c);
        return (c % 3 == 2) ? c - 2 : c + 1;
    endfunction

    function automatic bit edge_counts(int esel, bit rising);
        case (esel)
            0: return !rising;
            1: return rising;
            2: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_event(int c);
        int cur = c;
        bit go  = 1;
        while (go) begin
            go = 0;
            if (run[cur] && op_mode[cur] == 2'b01) begin
                m_seen[cur] = 1;
                if (m_cnt[cur] == 0) begin
                    m_cnt[cur] = m_rel[cur];
                    m_irq[cur]++;
                    if (src_casc[consumer_of(cur)]) begin
                        cur = consumer_of(cur);
                        go  = 1;
                    end
                end else begin
                    m_cnt[cur]--;
                end
            end
        end
    endtask

    task automatic check_all(string tag);
        for (int c = 0; c < NCH; c++) begin
            @(negedge clk);
            rd_sel = 3'(c);
            #1;
            check($sformatf("%s cnt ch%0d", tag, c), int'(rd_data), m_cnt[c]);
            check($sformatf("%s irq ch%0d", tag, c), irq_seen[c], m_irq[c]);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pin(int c);
        bit rising;
        @(negedge clk);
        ext_in[c] = ~ext_in[c];
        rising = ext_in[c];
        if (!src_casc[c] && edge_counts(int'(edge_mode[c]), rising)) model_event(c);
        idle(8);
    endtask

    task automatic wr(int c, int v);
        @(negedge clk);
        wr_en = 1; wr_sel = 3'(c); wr_data = CW'(v);
        m_rel[c] = v;
        if (!(run[c] && m_seen[c])) m_cnt[c] = v;
        @(negedge clk);
        wr_en = 0;
        idle(2);
    endtask

    task automatic set_run(int c, bit b);
        @(negedge clk);
        run[c] = b;
        if (!b) m_seen[c] = 0;
        idle(2);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4711));
        rst_n = 0; ext_in = '0; run = '0; src_casc = '0;
        wr_en = 0; wr_sel = '0; wr_data = '0; rd_sel = '0;
        for (int c = 0; c < NCH; c++) begin
            op_mode[c] = 2'b01; edge_mode[c] = 2'b00;
            m_cnt[c] = 0; m_rel[c] = 0; m_seen[c] = 0; m_irq[c] = 0; irq_seen[c] = 0;
        end
        idle(3);
        rst_n = 1;
        check_all("R8 reset");

        // R4 writes while stopped and before the first event
        wr(0, 5);
        check_all("R4 stopped write");
        set_run(0, 1);
        wr(0, 7);
        check_all("R4 early write");
        pin(0);
        check_all("R2 rise ignored for falling mode");
        pin(0);
        check_all("R1 falling edge counted");
        wr(0, 3);
        check_all("R5 late write reload only");
        for (int k = 0; k < 7; k++) begin pin(0); pin(0); end
        check_all("R5 R6 wrap uses new reload");

        // R12 and R6 timing, channel 0 at 3 -> bring to 0
        for (int k = 0; k < 3; k++) begin pin(0); pin(0); end
        pin(0);
        rd_sel = 3'd0;
        @(negedge clk);
        ext_in[0] = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R12 not yet counted", int'(rd_data), 0);
        check("R12 irq not yet", int'(irq[0]), 0);
        @(negedge clk);
        check("R12 counted at second edge", int'(rd_data), 3);
        check("R6 irq raised", int'(irq[0]), 1);
        @(negedge clk);
        check("R6 irq one cycle", int'(irq[0]), 0);
        model_event(0);
        idle(4);
        check_all("R6 after timing");

        // R9 restart and R11 reload zero
        set_run(0, 0);
        set_run(0, 1);
        wr(0, 0);
        check_all("R9 restart write loads both");
        for (int k = 0; k < 3; k++) begin pin(0); pin(0); end
        check_all("R11 reload zero every event");

        // R3 cascade
        src_casc[1] = 1;
        set_run(1, 1);
        wr(1, 2);
        for (int k = 0; k < 4; k++) begin pin(0); pin(0); end
        check_all("R3 cascade from ch0");
        set_run(5, 1);
        wr(5, 0);
        src_casc[3] = 1;
        set_run(3, 1);
        wr(3, 1);
        for (int k = 0; k < 2; k++) begin pin(5); pin(5); end
        check_all("R3 wrap partner ch5");
        edge_mode[3] = 2'b10;
        for (int k = 0; k < 2; k++) pin(3);
        check_all("R3 pin ignored under cascade");

        // R2 both edges and reserved code
        edge_mode[4] = 2'b10;
        set_run(4, 1);
        wr(4, 10);
        for (int k = 0; k < 4; k++) pin(4);
        check_all("R2 both edges");
        edge_mode[4] = 2'b11;
        for (int k = 0; k < 4; k++) pin(4);
        check_all("R2 reserved counts nothing");

        // R7 mode and stop
        edge_mode[4] = 2'b10;
        op_mode[4] = 2'b00;
        for (int k = 0; k < 2; k++) pin(4);
        check_all("R7 wrong mode holds");
        op_mode[4] = 2'b01;
        set_run(4, 0);
        for (int k = 0; k < 2; k++) pin(4);
        check_all("R7 stopped holds");

        // R10 simultaneous write and event after first event
        set_run(4, 1);
        wr(4, 4);
        pin(4);
        @(negedge clk);
        ext_in[4] = ~ext_in[4];
        @(negedge clk);
        @(negedge clk);
        wr_en = 1; wr_sel = 3'd4; wr_data = 16'd9;
        model_event(4);
        m_rel[4] = 9;
        @(negedge clk);
        wr_en = 0;
        idle(4);
        check_all("R10 event wins counter");
        for (int k = 0; k < 3; k++) pin(4);
        check_all("R10 new reload at wrap");

        // Random mix
        for (int n = 0; n < 300; n++) begin
            int c;
            int op;
            c  = int'($urandom_range(NCH - 1));
            op = int'($urandom_range(9));
            if (op < 5) begin
                pin(c);
            end else if (op < 7) begin
                wr(c, ($urandom_range(3) == 0) ? int'($urandom_range(16'hFFFF)) : int'($urandom_range(3)));
            end else if (op == 7) begin
                set_run(c, ~run[c]);
            end else begin
                edge_mode[c] = 2'($urandom_range(3));
                if (c % 3 != 0) src_casc[c] = 1'($urandom_range(1));
                idle(2);
            end
            check_all("R1 R8 random");
        end

        finish_run();
    end

endmodule